// File: doc/BRIEF.md
# Vector-Steered Receive Word Packer

The packer sits behind a serial receiver. It takes one bit per accepted cycle and writes it into a 32-bit receive FIFO entry. The bit's position in the entry is set by a small program of up to four chunk descriptors rather than by a fixed shift direction. Each descriptor names:

- a starting bit position;
- a walking direction;
- a chunk length of one to eight bits;
- a flag that marks the end of the entry.

Chunks are consumed in order. A protocol word wider than eight bits spans several consecutive descriptors whose start positions are eight apart. The start positions step downward for most-significant-bit-first traffic and upward for least-significant-bit-first traffic.

When the final chunk completes, the assembled entry is offered on a valid/ready output. The entry carries a 2-bit granularity code that tells the consumer how many protocol words it holds:

- 0 means four words of up to 8 bits;
- 1 means two words of up to 16 bits;
- 2 means one word of up to 32 bits.

Code 3 has no meaning and is reported on an error line. A synchronous flush abandons a half-built entry.

Top module: `rx_word_packer`

## Requirements
- R1: After reset, word_valid is 0, bit_ready is 1, and the first entry contains only bits received after reset (all other positions are 0).
- R2: Descriptor d is taken from cfg_lo[9:0] (d=0), cfg_lo[19:10] (d=1), cfg_hi[9:0] (d=2) or cfg_hi[19:10] (d=3). Within a descriptor, [9:5] is the start position s, bit 4 the direction (1 = downward), [3:1] the chunk length minus one, and bit 0 the stop flag. The k-th bit of a chunk lands at s-k (downward) or s+k (upward), modulo 32. A later bit written to the same position overrides an earlier one.
- R3: Descriptors are used in the order 0,1,2,3, each for length+1 accepted bits. The entry completes on the last bit of a descriptor with its stop flag set, or on the last bit of descriptor 3. word_valid is 1 in the cycle after the clock edge that accepted that bit.
- R4: Entry positions that no chunk writes are 0 in the emitted entry, whatever earlier entries held.
- R5: While word_valid is 1 and word_ready is 0, word_data and word_valid hold, bit_ready is 0, and offered bits are ignored.
- R6: word_gran equals the gran input at the edge that completed the entry. gran_err is 1 exactly when gran is 3, and entries are still produced unchanged in that case.
- R7: A flush discards the partial entry and any bit offered in the same cycle, and the next bit starts descriptor 0 of a fresh entry. An entry already waiting on the output is kept.
- R8: When word_valid and word_ready are both 1, a bit is accepted in the same cycle, so entries can be produced back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard the partial entry and restart at descriptor 0 |
| bit_valid | input | 1 | A received bit is offered |
| bit_data | input | 1 | Received bit value |
| bit_ready | output | 1 | Packer can accept a bit this cycle |
| cfg_lo | input | 32 | Descriptors 0 and 1 |
| cfg_hi | input | 32 | Descriptors 2 and 3 |
| gran | input | 2 | Granularity code for new entries |
| word_valid | output | 1 | An assembled entry is offered |
| word_data | output | 32 | Assembled entry |
| word_gran | output | 2 | Granularity code captured with the entry |
| word_ready | input | 1 | Consumer takes the offered entry |
| gran_err | output | 1 | Granularity code 3 is selected |

## Verification
A wrong descriptor index or bit counter shows up at once in the first affected entry. Bits land at the wrong positions, or the entry is offered one or more bits early or late. The bench therefore checks both the content and the exact cycle of every entry.

An assembly register that is not cleared between entries leaks set bits into positions that should be zero in the next entry. A stall that does not freeze the state corrupts the entry that follows the stall.

Sweeping every word width from 1 to 32, in both bit orders and every legal packing, exercises every descriptor start and length combination that the packing rules can produce.

// File: rtl/rx_word_packer.sv
module rx_word_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        bit_valid,
  input  logic        bit_data,
  output logic        bit_ready,
  input  logic [31:0] cfg_lo,
  input  logic [31:0] cfg_hi,
  input  logic [1:0]  gran,
  output logic        word_valid,
  output logic [31:0] word_data,
  output logic [1:0]  word_gran,
  input  logic        word_ready,
  output logic        gran_err
);
  localparam int WORD_W = 32;
  localparam int POS_W  = $clog2(WORD_W);
  localparam int VEC_W  = 10;
  localparam int NVEC   = 4;
  localparam int IDX_W  = $clog2(NVEC);
  localparam int CNT_W  = 3;

  logic [IDX_W-1:0]  vidx;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] asm_q, asm_n;
  logic [VEC_W-1:0]  vec;

  always_comb begin
    case (vidx)
      2'd0:    vec = cfg_lo[VEC_W-1:0];
      2'd1:    vec = cfg_lo[2*VEC_W-1:VEC_W];
      2'd2:    vec = cfg_hi[VEC_W-1:0];
      default: vec = cfg_hi[2*VEC_W-1:VEC_W];
    endcase
  end

  wire [POS_W-1:0] vstart = vec[9:5];
  wire             vdown  = vec[4];
  wire [CNT_W-1:0] vlen   = vec[3:1];
  wire             vstop  = vec[0];

  wire [POS_W-1:0] pos = vdown ? vstart - {2'b00, cnt} : vstart + {2'b00, cnt};

  assign bit_ready = !word_valid || word_ready;
  assign gran_err  = (gran == 2'b11);

  wire take      = bit_valid && bit_ready && !flush;
  wire chunk_end = (cnt == vlen);
  wire entry_end = take && chunk_end && (vstop || vidx == IDX_W'(NVEC-1));

  always_comb begin
    asm_n = asm_q;
    asm_n[pos] = bit_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_data  <= '0;
      word_gran  <= '0;
    end else begin
      if (word_valid && word_ready) word_valid <= 1'b0;
      if (entry_end) begin
        word_valid <= 1'b1;
        word_data  <= asm_n;
        word_gran  <= gran;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vidx  <= '0;
      cnt   <= '0;
      asm_q <= '0;
    end else if (take) begin
      if (entry_end) begin
        vidx  <= '0;
        cnt   <= '0;
        asm_q <= '0;
      end else if (chunk_end) begin
        vidx  <= vidx + 1'b1;
        cnt   <= '0;
        asm_q <= asm_n;
      end else begin
        cnt   <= cnt + 1'b1;
        asm_q <= asm_n;
      end
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data) && $stable(word_gran)));

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready && !flush) |=> ($stable(vidx) && $stable(cnt) && $stable(asm_q)));

  assert_gran_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> (word_gran == $past(gran)));

  assert_flush_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vidx == '0 && cnt == '0 && asm_q == '0));

  assert_fresh_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> (asm_q == '0));
endmodule

// File: tb/rx_word_packer_test.sv
module rx_word_packer_test;
  localparam time PERIOD = 8ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready;
  logic [31:0] cfg_lo = '0;
  logic [31:0] cfg_hi = '0;
  logic [1:0] gran = '0;
  logic word_valid;
  logic [31:0] word_data;
  logic [1:0] word_gran;
  logic word_ready = 1'b0;
  logic gran_err;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  rx_word_packer uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .gran(gran),
    .word_valid(word_valid), .word_data(word_data), .word_gran(word_gran),
    .word_ready(word_ready), .gran_err(gran_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] get_vec(input logic [31:0] lo, input logic [31:0] hi, input int d);
    logic [31:0] w;
    w = (d < 2) ? lo : hi;
    return 10'((w >> (10 * (d % 2))) & 32'h3ff);
  endfunction

  function automatic logic [31:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                        input logic [31:0] bits, output int nbits);
    logic [31:0] w;
    w = '0;
    nbits = 0;
    for (int d = 0; d < 4; d++) begin
      logic [9:0] v;
      int s;
      v = get_vec(lo, hi, d);
      s = int'(v[9:5]);
      for (int k = 0; k <= int'(v[3:1]); k++) begin
        int p;
        p = (v[4] ? (s - k) : (s + k)) & 31;
        w[p] = bits[nbits];
        nbits++;
      end
      if (v[0]) break;
    end
    return w;
  endfunction

  task automatic gen_cfg(input int bpw, input int pack, input bit msb,
                         output logic [31:0] lo, output logic [31:0] hi);
    logic [9:0] c [4];
    int ceil8, iter, idx0, idx, rem, ln;
    ceil8 = ((bpw + 7) / 8) * 8;
    iter = ceil8 * pack / 8;
    idx0 = msb ? bpw - 1 : 0;
    idx = idx0;
    rem = bpw;
    for (int i = 0; i < 4; i++) c[i] = '0;
    for (int i = 0; i < iter; i++) begin
      ln = ((rem < 8) ? rem : 8) - 1;
      c[i] = {5'(idx), msb, 3'(ln), 1'b0};
      if (rem <= 8) begin
        idx = (i + 1) * 8 + idx0;
        rem = bpw;
      end else begin
        idx = msb ? idx - 8 : idx + 8;
        rem = rem - 8;
      end
    end
    c[iter-1][0] = 1'b1;
    lo = {12'h0, c[1], c[0]};
    hi = {12'h0, c[3], c[2]};
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      bit_valid = 1'b1;
      bit_data = bits[i];
      @(negedge clk);
    end
    bit_valid = 1'b0;
  endtask

  task automatic take_word();
    word_ready = 1'b1;
    @(negedge clk);
    word_ready = 1'b0;
  endtask

  task automatic run_entry(input string req, input logic [31:0] lo, input logic [31:0] hi,
                           input logic [1:0] g);
    logic [31:0] bits, exp;
    int n;
    cfg_lo = lo;
    cfg_hi = hi;
    gran = g;
    bits = $urandom;
    exp = model(lo, hi, bits, n);
    send_bits(bits, n);
    chk({req, " valid"}, 32'(word_valid), 32'd1);
    chk({req, " data"}, word_data, exp);
    chk({req, " gran"}, 32'(word_gran), 32'(g));
    take_word();
  endtask

  initial begin
    #(PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lo, hi, bits, exp, held;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset valid", 32'(word_valid), 32'd0);
    chk("R1 reset ready", 32'(bit_ready), 32'd1);
    chk("R6 gran_err low", 32'(gran_err), 32'd0);

    cfg_lo = {12'h0, 10'h0, 5'd3, 1'b0, 3'd2, 1'b1};
    cfg_hi = '0;
    send_bits(32'h7, 3);
    chk("R1 first entry only new bits", word_data, 32'h38);
    take_word();

    for (int bpw = 1; bpw <= 32; bpw++) begin
      for (int m = 0; m < 2; m++) begin
        for (int pack = 1; pack <= 4; pack *= 2) begin
          if (((bpw + 7) / 8) * pack <= 4) begin
            gen_cfg(bpw, pack, m[0], lo, hi);
            run_entry("R2 R3 sweep", lo, hi, (bpw <= 8) ? 2'd0 : (bpw <= 16) ? 2'd1 : 2'd2);
          end
        end
      end
    end

    lo = {12'h0, 5'd8, 1'b0, 3'd7, 1'b0, 5'd0, 1'b0, 3'd7, 1'b0};
    hi = {12'h0, 5'd24, 1'b0, 3'd7, 1'b0, 5'd16, 1'b0, 3'd7, 1'b0};
    cfg_lo = lo;
    cfg_hi = hi;
    send_bits(32'hdead_beef, 31);
    chk("R3 not done before last bit", 32'(word_valid), 32'd0);
    send_bits(32'h1, 1);
    chk("R3 descriptor 3 ends entry", word_data, 32'hdead_beef);
    take_word();

    cfg_lo = {12'h0, 10'h0, 5'd31, 1'b1, 3'd7, 1'b1};
    cfg_hi = '0;
    send_bits(32'hff, 8);
    take_word();
    cfg_lo = {12'h0, 10'h0, 5'd30, 1'b1, 3'd2, 1'b1};
    send_bits(32'h7, 3);
    chk("R4 uncovered bits zero", word_data, 32'h7000_0000);
    take_word();

    cfg_lo = {12'h0, 10'h0, 5'd1, 1'b0, 3'd0, 1'b1};
    send_bits(32'h1, 1);
    chk("R2 position modulo", word_data, 32'h2);
    take_word();
    cfg_lo = {12'h0, 10'h0, 5'd1, 1'b1, 3'd3, 1'b1};
    send_bits(32'hf, 4);
    chk("R2 downward wrap", word_data, 32'hc000_0003);
    take_word();

    gen_cfg(8, 4, 1'b1, lo, hi);
    cfg_lo = lo;
    cfg_hi = hi;
    gran = 2'd0;
    bits = 32'h1234_5678;
    exp = model(lo, hi, bits, n);
    send_bits(bits, n);
    held = word_data;
    chk("R5 entry offered", held, exp);
    bit_valid = 1'b1;
    bit_data = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 bit_ready low", 32'(bit_ready), 32'd0);
      chk("R5 data held", word_data, held);
      chk("R5 valid held", 32'(word_valid), 32'd1);
    end
    bit_valid = 1'b0;
    take_word();
    chk("R5 valid drops after take", 32'(word_valid), 32'd0);
    bits = 32'h0f0f_0000;
    exp = model(lo, hi, bits, n);
    send_bits(bits, n);
    chk("R5 stalled bits ignored", word_data, exp);
    take_word();

    gran = 2'd3;
    @(negedge clk);
    chk("R6 gran_err high", 32'(gran_err), 32'd1);
    run_entry("R6 entry with code 3", lo, hi, 2'd3);
    gran = 2'd1;
    @(negedge clk);
    chk("R6 gran_err clears", 32'(gran_err), 32'd0);

    send_bits(32'h1f, 5);
    flush = 1'b1;
    bit_valid = 1'b1;
    bit_data = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    bit_valid = 1'b0;
    chk("R7 no entry from flush", 32'(word_valid), 32'd0);
    bits = 32'h00a5_c300;
    exp = model(lo, hi, bits, n);
    send_bits(bits, n);
    chk("R7 fresh entry after flush", word_data, exp);
    held = word_data;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk("R7 held entry kept valid", 32'(word_valid), 32'd1);
    chk("R7 held entry kept data", word_data, held);
    take_word();

    cfg_lo = {12'h0, 10'h0, 5'd4, 1'b0, 3'd1, 1'b1};
    cfg_hi = '0;
    word_ready = 1'b1;
    bits = 32'b10_01_11;
    for (int i = 0; i < 6; i++) begin
      bit_valid = 1'b1;
      bit_data = bits[i];
      chk("R8 accepted while taking", 32'(bit_ready), 32'd1);
      @(negedge clk);
      if (i % 2 == 1) begin
        chk("R8 back to back valid", 32'(word_valid), 32'd1);
        chk("R8 back to back data", word_data, 32'(bits[i -: 2]) << 4);
      end else begin
        chk("R8 gap valid", 32'(word_valid), 32'd0);
      end
    end
    bit_valid = 1'b0;
    word_ready = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule